// File: doc/BRIEF.md
# Opcode-Fetch Wait-State Inserter

This block sits next to a Z80-style processor bus and drives the active-low wait line. Its job is to lengthen every opcode-fetch machine cycle by exactly one clock. That lets slower board logic keep up during the fetch, whose last two clocks are taken by DRAM refresh. Plain memory reads, memory writes and I/O cycles get no wait. Operand bytes such as immediates, addresses, displacements and port numbers are fetched with the M1 strobe high, so they run at full speed. A prefixed instruction makes two opcode fetches, so it pays two waits.

The block registers the M1 strobe and treats a high-to-low change of M1, seen with MREQ low and IORQ high, as the start of a fetch. It then pulls wait_n low for the single clock that follows T1. The processor samples it once, inserts one Tw state, and the fetch becomes T1, Tw, T2, T3, T4. An enable input turns the stretching off, which gives bare timing for comparison.

A clocks-per-instruction counter is included for self-checking. The opcode byte is captured from the data bus during each fetch. The counter restarts at every fetch that does not continue a prefixed instruction.

Top module: `opfetch_wait`

## Requirements
- R1: While rst is high at a rising clock edge, wait_n is driven high on the next clock and cpi_count is 0.
- R2: With en high, each fetch start pulls wait_n low for exactly one clock, beginning the clock after T1. A fetch start is an edge where m1_n is low while it was high at the previous edge, with mreq_n low and iorq_n high. An unprefixed opcode fetch then lasts 5 clocks instead of 4.
- R3: Machine cycles with m1_n high never see wait_n low. A memory read or write stays 3 clocks and an I/O cycle stays 4 clocks.
- R4: An M1 cycle with iorq_n low (interrupt acknowledge) gets no wait and does not restart the counter.
- R5: A prefixed instruction receives one wait per opcode fetch, so two in total. A byte counts as a prefix if it is 0xDD or 0xFD, or if it is 0xCB or 0xED and does not itself follow a prefix byte. The sequence DD CB d op therefore has two opcode fetches.
- R6: With en low, wait_n stays high and every opcode fetch lasts 4 clocks.
- R7: The opcode is captured from data_in on each edge where m1_n, mreq_n and rd_n are low and iorq_n is high. cpi_count is set to 1 at the end of T1 of a fetch that follows a non-prefix byte, and otherwise rises by 1 each clock. During T1 of an instruction's first fetch it therefore reads the clock length of the previous instruction.
- R8: cpi_count saturates at 2^CNT_W-1 (255 by default) instead of wrapping.
- R9: With en high, a 13-clock instruction (one fetch plus three reads) takes 14 clocks, and three 4-clock instructions take 15 clocks. With en low they take 13 and 12 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, one T-state per period |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | High enables wait insertion |
| m1_n | input | 1 | Active-low machine-cycle-one strobe |
| mreq_n | input | 1 | Active-low memory request |
| rd_n | input | 1 | Active-low read strobe |
| iorq_n | input | 1 | Active-low I/O request |
| data_in | input | 8 | Data bus, sampled for the opcode during a fetch |
| wait_n | output | 1 | Active-low wait to the processor |
| cpi_count | output | CNT_W | Clocks counted since the last instruction start |

## Verification
The bench drives a cycle-level processor model that inserts a Tw state for every clock in which it sees wait_n low. Cycle lengths are therefore measured from how the processor actually responds, not read from the block.

The bench targets specific mistakes:
- A wait held for two clocks would make fetches 6 clocks long.
- Waiting on every memory access would stretch reads and operand bytes.
- Missing the second fetch of CB, ED, DD or FD instructions would leave them one clock short.
- Treating the CB inside DD CB d op as another prefix would stop the counter from restarting on the next instruction.
- Interrupt-acknowledge cycles, long idle stretches that drive the counter to saturation, and switching the enable off show whether a wait leaks into cycles that must run bare.

// File: rtl/opfetch_wait.sv
module opfetch_wait #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             m1_n,
  input  logic             mreq_n,
  input  logic             rd_n,
  input  logic             iorq_n,
  input  logic [7:0]       data_in,
  output logic             wait_n,
  output logic [CNT_W-1:0] cpi_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [7:0] OP_BITS = 8'hCB;
  localparam logic [7:0] OP_EXT  = 8'hED;
  localparam logic [7:0] OP_IX   = 8'hDD;
  localparam logic [7:0] OP_IY   = 8'hFD;

  logic       m1_q;
  logic       wait_q;
  logic       pfx_q;
  logic [7:0] op_q;

  wire fetch_bus   = !m1_n && !mreq_n && iorq_n;
  wire fetch_start = fetch_bus && m1_q;
  wire op_capture  = fetch_bus && !rd_n;
  wire index_pfx   = (op_q == OP_IX) || (op_q == OP_IY);
  wire group_pfx   = ((op_q == OP_BITS) || (op_q == OP_EXT)) && !pfx_q;
  wire pfx_now     = index_pfx || group_pfx;

  always_ff @(posedge clk) begin
    if (rst) begin
      m1_q   <= 1'b1;
      wait_q <= 1'b0;
      pfx_q  <= 1'b0;
      op_q   <= '0;
    end else begin
      m1_q   <= m1_n;
      wait_q <= en && fetch_start;
      if (op_capture)  op_q  <= data_in;
      if (fetch_start) pfx_q <= pfx_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cpi_count <= '0;
    else if (fetch_start && !pfx_now)
      cpi_count <= CNT_W'(1);
    else if (cpi_count != CNT_MAX)
      cpi_count <= cpi_count + 1'b1;
  end

  assign wait_n = !wait_q;

endmodule

// File: rtl/opfetch_wait_chk.sv
module opfetch_wait_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             m1_n,
  input logic             mreq_n,
  input logic             iorq_n,
  input logic             wait_n,
  input logic [CNT_W-1:0] cpi_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (wait_n && cpi_count == '0));

  p_single_wait_r2: assert property (@(posedge clk) disable iff (rst)
    !wait_n |=> wait_n);

  p_wait_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_n) |-> $past(!m1_n && !mreq_n && iorq_n));

  p_wait_in_m1_r3: assert property (@(posedge clk) disable iff (rst)
    !wait_n |-> !m1_n);

  p_no_ack_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (!m1_n && !iorq_n) |=> wait_n);

  p_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> wait_n);

  p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
    (m1_n && cpi_count != CNT_MAX) |=> cpi_count == $past(cpi_count) + 1'b1);

  p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
    (m1_n && cpi_count == CNT_MAX) |=> cpi_count == CNT_MAX);

endmodule

bind opfetch_wait opfetch_wait_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .m1_n(m1_n), .mreq_n(mreq_n),
  .iorq_n(iorq_n), .wait_n(wait_n), .cpi_count(cpi_count)
);

// File: tb/opfetch_wait_tb.sv
module opfetch_wait_tb;

  localparam int CNT_W = 8;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int K_M1 = 0, K_RD = 1, K_WR = 2, K_IO = 3, K_ACK = 4;
  localparam int PK_NONE = 0, PK_CB = 1, PK_ED = 2, PK_DD = 3, PK_FD = 4, PK_DDCB = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic m1_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, iorq_n = 1'b1;
  logic [7:0] data_in = 8'hFF;
  logic wait_n;
  logic [CNT_W-1:0] cpi_count;

  int checks = 0, fails = 0;
  int clocks = 0, lead_clk = 0;
  bit have_lead = 0, done = 0;

  always #10 clk = !clk;

  opfetch_wait #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .m1_n(m1_n), .mreq_n(mreq_n),
    .rd_n(rd_n), .iorq_n(iorq_n), .data_in(data_in),
    .wait_n(wait_n), .cpi_count(cpi_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CNT_MAX) ? CNT_MAX : v;
  endfunction

  function automatic logic [7:0] nonpfx(input logic [7:0] b);
    if (b == 8'hCB || b == 8'hED || b == 8'hDD || b == 8'hFD) return 8'h00;
    return b;
  endfunction

  task automatic release_bus();
    m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; iorq_n = 1'b1; data_in = 8'hFF;
  endtask

  task automatic mcycle(input int kind, input logic [7:0] d, input bit lead);
    int tw = 0;
    int base;
    string req;
    @(negedge clk);
    if (kind == K_M1 && lead) begin
      if (have_lead) check("R7", int'(cpi_count), sat(clocks - lead_clk));
      lead_clk = clocks;
      have_lead = 1;
    end
    case (kind)
      K_M1:  begin m1_n = 0; mreq_n = 0; rd_n = 0; data_in = d; end
      K_RD:  begin mreq_n = 0; rd_n = 0; data_in = d; end
      K_WR:  begin mreq_n = 0; end
      K_IO:  begin iorq_n = 0; rd_n = 0; end
      default: begin m1_n = 0; iorq_n = 0; end
    endcase
    clocks++;
    @(negedge clk);
    while (!wait_n) begin
      tw++; clocks++;
      @(negedge clk);
    end
    clocks++;
    base = (kind == K_RD || kind == K_WR) ? 3 : 4;
    for (int p = 3; p <= base; p++) begin
      @(negedge clk);
      clocks++;
      if (kind == K_M1 && p == 3) begin
        m1_n = 1; rd_n = 1; mreq_n = 0; data_in = 8'hFF;
      end else if (kind == K_M1 || p == base) begin
        release_bus();
      end
    end
    if (kind == K_M1) req = !en ? "R6" : (lead ? "R2" : "R5");
    else if (kind == K_ACK) req = "R4";
    else req = "R3";
    check(req, tw, (kind == K_M1 && en) ? 1 : 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clocks++;
    end
  endtask

  task automatic exec(input int pk, input logic [7:0] b0, input logic [7:0] b1,
                      input int nrd, input int nint, input bit wr, input bit io,
                      output int len);
    int start = clocks;
    int nm1 = (pk == PK_NONE) ? 1 : 2;
    int w = en ? 1 : 0;
    int exp;
    logic [7:0] first;
    case (pk)
      PK_CB:   first = 8'hCB;
      PK_ED:   first = 8'hED;
      PK_DD:   first = 8'hDD;
      PK_FD:   first = 8'hFD;
      PK_DDCB: first = 8'hDD;
      default: first = b0;
    endcase
    mcycle(K_M1, first, 1);
    if (pk == PK_DDCB) mcycle(K_M1, 8'hCB, 0);
    else if (pk != PK_NONE) mcycle(K_M1, b1, 0);
    for (int i = 0; i < nrd; i++) mcycle(K_RD, 8'(i + 1), 0);
    idle(nint);
    if (wr) mcycle(K_WR, 8'h00, 0);
    if (io) mcycle(K_IO, 8'h00, 0);
    len = clocks - start;
    exp = nm1 * (4 + w) + 3 * nrd + nint + (wr ? 3 : 0) + (io ? 4 : 0);
    check(pk == PK_NONE ? (en ? "R2" : "R6") : "R5", len, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", clocks, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int len, a, b, c;
    int pk, nrd, nint;
    logic [7:0] b0, b1;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1", int'(wait_n), 1);
    check("R1", int'(cpi_count), 0);
    rst = 1'b0;

    // R9 worked examples with the inserter active
    exec(PK_NONE, 8'h3A, 8'h00, 3, 0, 0, 0, len);
    check("R9", len, 14);
    exec(PK_NONE, 8'hD9, 0, 0, 0, 0, 0, a);
    exec(PK_NONE, 8'h78, 0, 0, 0, 0, 0, b);
    exec(PK_NONE, 8'hD9, 0, 0, 0, 0, 0, c);
    check("R9", a + b + c, 15);

    // R9 / R6 bare timing
    en = 1'b0;
    exec(PK_NONE, 8'h3A, 8'h00, 3, 0, 0, 0, len);
    check("R9", len, 13);
    exec(PK_NONE, 8'hD9, 0, 0, 0, 0, 0, a);
    exec(PK_NONE, 8'h78, 0, 0, 0, 0, 0, b);
    exec(PK_NONE, 8'hD9, 0, 0, 0, 0, 0, c);
    check("R9", a + b + c, 12);
    en = 1'b1;

    // R5 each prefix, including the double-prefix bit form
    exec(PK_CB, 8'h00, 8'h47, 0, 0, 0, 0, len);
    check("R5", len, 10);
    exec(PK_ED, 8'h00, 8'hB0, 0, 5, 1, 0, len);
    exec(PK_DD, 8'h00, 8'h21, 2, 0, 0, 0, len);
    exec(PK_FD, 8'h00, 8'h7E, 1, 5, 0, 0, len);
    exec(PK_DDCB, 8'h00, 8'h00, 2, 2, 1, 0, len);
    exec(PK_NONE, 8'h00, 8'h00, 0, 0, 0, 0, len);

    // R4 interrupt acknowledge between instructions
    mcycle(K_ACK, 8'h00, 0);
    exec(PK_NONE, 8'h00, 8'h00, 0, 1, 0, 0, len);

    // R3 I/O and writes
    exec(PK_NONE, 8'hD3, 8'h00, 1, 0, 0, 1, len);
    check("R3", len, 12);

    // R8 saturation across a long stall
    exec(PK_NONE, 8'h76, 8'h00, 0, 300, 0, 0, len);
    exec(PK_NONE, 8'h00, 8'h00, 0, 0, 0, 0, len);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      pk   = $urandom_range(0, 5);
      b0   = nonpfx(8'($urandom));
      b1   = nonpfx(8'($urandom));
      nrd  = (pk == PK_DDCB) ? 2 : $urandom_range(0, 2);
      nint = $urandom_range(0, 3);
      exec(pk, b0, b1, nrd, nint, $urandom_range(0, 3) == 0,
           $urandom_range(0, 4) == 0, len);
      if ($urandom_range(0, 7) == 0) mcycle(K_ACK, 8'h00, 0);
      if ($urandom_range(0, 19) == 0) en = !en;
    end
    exec(PK_NONE, 8'h00, 8'h00, 0, 0, 0, 0, len);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule